// File: doc/BRIEF.md
# SPI Controller with Write-Collision Guard

This block is a byte-wide SPI port that can run as master or as slave. Software reaches it through two registers, selected by a one-bit address. The data register takes the next byte to send on a write and returns the last received byte on a read. The status register reports a completion flag and a write-collision flag. As master, the block makes SCK from the system clock with a fixed divider. As slave, it takes SCK, SS and MOSI from the pins through a synchronizer, so the external SCK must be much slower than the system clock.

The shifting byte is protected. A write to the data register while a transfer owns the shifter is thrown away, the byte on the wire finishes unchanged, and a sticky collision flag is raised. The window in which a write counts as a collision depends on the role and on the clock phase. Both flags are cleared by a two-step access sequence: a status read, then a data-register access. An internal armed bit tracks the first step. The interrupt output follows only the completion flag.

Top module: `spi_wcol_ctrl`

## Requirements
- R1: After reset, both flags are 0, `irq` is 0, a data read returns 0, `sck_o` rests at the `cfg_cpol` level and `miso_oe` is 0.
- R2: As master, an accepted data write starts an 8-bit MSB-first transfer. `sck_o` idles at `cfg_cpol`, and each SCK half period lasts HALF_DIV clocks. With `cfg_cpha`=0, data is sampled on the leading edge; with `cfg_cpha`=1, it is sampled on the trailing edge. `irq` and the completion flag (status bit 7) rise 16*HALF_DIV clocks after the write, and the received byte is then readable at the data register (address 0).
- R3: A data write that collides is discarded: the byte being shifted out is completed unchanged.
- R4: A colliding write sets the collision flag (status bit 6) in both roles. This flag never drives `irq`.
- R5: As master, the collision window runs from the accepted write until the 16th SCK edge of that byte.
- R6: As slave with `cfg_cpha`=0, every data write made while SS is low collides, including writes after a byte has completed. `miso_o` shows the MSB and `miso_oe` is 1 as soon as SS is low.
- R7: As slave with `cfg_cpha`=1, a data write with SS low before the first SCK edge is accepted. The first SCK edge opens the collision window and enables `miso_oe`, and the MSB of the loaded byte is presented first.
- R8: A status read (address 1) followed by a data read clears both flags.
- R9: A status read followed by a data write clears the completion flag. The collision flag then ends at 0 if the write is accepted and at 1 if it collides.
- R10: While no completed byte is pending, a status read followed by a data read clears the collision flag, but a status read followed by a data write does not.
- R11: A data read with no preceding status read, or any write to the status register, leaves both flags unchanged. A data read never collides.
- R12: As slave, the byte shifted in on MOSI becomes readable at the data register when the byte completes, and the loaded byte goes out on `miso_o` MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master | input | 1 | 1 = master role, 0 = slave role; changed only while idle |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data register, 1 = status register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register (combinational) |
| irq | output | 1 | Completion interrupt |
| sck_o | output | 1 | Master SCK |
| mosi_o | output | 1 | Master serial out |
| miso_i | input | 1 | Master serial in |
| sck_i | input | 1 | Slave SCK |
| ss_n_i | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Slave serial in |
| miso_o | output | 1 | Slave serial out |
| miso_oe | output | 1 | Slave output enable for `miso_o` |

## Verification
The master path is tried in two ways. A clean loopback transfer in two SCK polarity and phase combinations checks bit order, SCK idle level and cycle count. Loopback transfers with a mid-byte write show whether the rejected byte leaks onto the wire or into the received data. The slave path is driven in both phases, with writes placed before SS falls, after SS falls but before the first edge, and in the middle of a byte; these placements tell the SS-based window apart from the first-edge window. The clearing logic is tried with read-then-read, read-then-write (both accepted and colliding), an unarmed data read and a status-register write, which separates a real sequence from stray accesses.

// File: rtl/spi_wc_pkg.sv
// Shared types for the SPI controller with write-collision guard.
package spi_wc_pkg;

    // Register selected by the one-bit bus address.
    typedef enum logic {
        REG_DATA = 1'b0,
        REG_STAT = 1'b1
    } reg_sel_e;

    // Decoded single-cycle register operation.
    typedef struct packed {
        logic rd_data;
        logic wr_data;
        logic rd_stat;
        logic wr_stat;
    } bus_op_t;

endpackage

// File: rtl/spi_wc_sync.sv
// Slave pin synchronizer and SCK edge finder.
// Brings SCK, SS and MOSI into the clk domain through STAGES flops and
// reports leading / trailing edges of SCK (relative to CPOL) while SS is low.
// Assumes the external SCK half period spans several clk cycles.
module spi_wc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpol,
    input  logic sck_i,
    input  logic ss_n_i,
    input  logic mosi_i,
    output logic s_lead,
    output logic s_trail,
    output logic s_ss_low,
    output logic s_mosi
);
    localparam int LAST = STAGES - 1;

    // bit0 = SCK, bit1 = SS_n, bit2 = MOSI
    logic [STAGES-1:0][2:0] stg_q;
    logic                   lvl_q;
    logic                   lvl;

    // Shift the pin samples through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= {STAGES{3'b010}};
        else        stg_q <= {stg_q[STAGES-2:0], {mosi_i, ss_n_i, sck_i}};
    end

    // Remember the previous normalized SCK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    // Normalize SCK to "0 = idle" and derive edges gated by SS.
    always_comb begin
        lvl      = stg_q[LAST][0] ^ cpol;
        s_ss_low = ~stg_q[LAST][1];
        s_mosi   = stg_q[LAST][2];
        s_lead   = s_ss_low & lvl & ~lvl_q;
        s_trail  = s_ss_low & ~lvl & lvl_q;
    end
endmodule

// File: rtl/spi_wc_clkdiv.sv
// Master SCK half-period tick generator.
// While run is high, pulses tick once every HALF_DIV clk cycles; the count
// restarts whenever run is low so each byte begins with a full half period.
module spi_wc_clkdiv #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [DW-1:0] div_q;

    // Terminal count of the divider while running.
    assign tick = run && (div_q == DW'(HALF_DIV - 1));

    // Divider counter, held at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)             div_q <= '0;
        else if (!run || tick)  div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/spi_wc_shift.sv
// Shift engine shared by master and slave roles.
// Counts the 2*W SCK edges of a byte, samples and shifts according to CPHA,
// latches the received byte into a buffer on the final edge and reports the
// collision window for the current role and phase.
// Assumes load is only asserted outside the collision window.
module spi_wc_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         is_master,
    input  logic         cpha,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         m_tick,
    input  logic         s_lead,
    input  logic         s_trail,
    input  logic         s_ss_low,
    input  logic         m_sin,
    input  logic         s_sin,
    output logic         window,
    output logic         done,
    output logic         out_bit,
    output logic         sck_lvl,
    output logic         mid_byte,
    output logic         m_busy,
    output logic [W-1:0] rx_data
);
    localparam int EDGES = 2 * W;
    localparam int CW    = $clog2(EDGES);

    logic [CW-1:0] cnt_q;
    logic [W-1:0]  out_q;
    logic [W-1:0]  rx_sr_q;
    logic [W-1:0]  rx_buf_q;
    logic          busy_q;
    logic          ev, is_lead, last, sin, do_sample, do_shift;

    // Decode the edge event, its kind and the sample / shift actions.
    always_comb begin
        ev        = is_master ? m_tick : (s_lead | s_trail);
        is_lead   = is_master ? ~cnt_q[0] : s_lead;
        last      = ev && (cnt_q == CW'(EDGES - 1));
        sin       = is_master ? m_sin : s_sin;
        do_sample = ev && (is_lead ^ cpha);
        do_shift  = ev && (cpha ? (is_lead && (cnt_q != '0)) : !is_lead);
    end

    // Edge counter; a slave aborts the byte when SS rises.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (!is_master && !s_ss_low) cnt_q <= '0;
        else if (ev)                      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end

    // Master transfer-in-progress flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                  busy_q <= 1'b0;
        else if (load && is_master)  busy_q <= 1'b1;
        else if (last)               busy_q <= 1'b0;
    end

    // Outgoing shift register, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_q <= '0;
        else if (load)     out_q <= load_data;
        else if (do_shift) out_q <= {out_q[W-2:0], 1'b0};
    end

    // Incoming shift register.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_sr_q <= '0;
        else if (do_sample) rx_sr_q <= {rx_sr_q[W-2:0], sin};
    end

    // Receive buffer, written once per completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n)    rx_buf_q <= '0;
        else if (last) rx_buf_q <= cpha ? {rx_sr_q[W-2:0], sin} : rx_sr_q;
    end

    // Collision window and pin-facing views.
    always_comb begin
        if (is_master)  window = busy_q;
        else if (cpha)  window = (cnt_q != '0) || s_lead;
        else            window = s_ss_low;
        done     = last;
        out_bit  = out_q[W-1];
        sck_lvl  = busy_q & cnt_q[0];
        mid_byte = (cnt_q != '0);
        m_busy   = busy_q;
        rx_data  = rx_buf_q;
    end
endmodule

// File: rtl/spi_wc_flags.sv
// Completion / collision flag keeper and clearing-sequence tracker.
// A status read arms the sequence; the next data-register access consumes it.
// Assumes at most one register operation per cycle.
module spi_wc_flags
    import spi_wc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  bus_op_t op,
    input  logic    window,
    input  logic    done,
    output logic    load,
    output logic    spif,
    output logic    wcol,
    output logic    armed
);
    logic spif_q, wcol_q, armed_q;
    logic collide, consume;

    // Classify the data write and detect the end of a sequence.
    always_comb begin
        collide = op.wr_data && window;
        load    = op.wr_data && !window;
        consume = armed_q && (op.wr_data || op.rd_data);
    end

    // Armed bit: set by a status read, dropped by any data access.
    always_ff @(posedge clk) begin
        if (!rst_n)                          armed_q <= 1'b0;
        else if (op.rd_stat)                 armed_q <= 1'b1;
        else if (op.wr_data || op.rd_data)   armed_q <= 1'b0;
    end

    // Completion flag: a new completion wins over a clearing sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)       spif_q <= 1'b0;
        else if (done)    spif_q <= 1'b1;
        else if (consume) spif_q <= 1'b0;
    end

    // Collision flag: set by a rejected write, cleared by read sequences
    // or by a write sequence that follows a completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  wcol_q <= 1'b0;
        else if (collide)                            wcol_q <= 1'b1;
        else if (consume && op.rd_data)              wcol_q <= 1'b0;
        else if (consume && op.wr_data && spif_q)    wcol_q <= 1'b0;
    end

    assign spif  = spif_q;
    assign wcol  = wcol_q;
    assign armed = armed_q;
endmodule

// File: rtl/spi_wcol_ctrl.sv
// SPI controller top: register decode, read mux and pin mapping.
// Master or slave role, MSB-first bytes, collision-protected data register.
// Assumes configuration inputs only change while no byte is in flight.
module spi_wcol_ctrl
    import spi_wc_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe
);
    localparam int DONE_BIT = DATA_W - 1;
    localparam int COLL_BIT = DATA_W - 2;

    bus_op_t           bus_op;
    reg_sel_e          reg_sel;
    logic              s_lead, s_trail, s_ss_low, s_mosi;
    logic              m_tick, m_busy;
    logic              coll_window, xfer_done, out_bit, sck_lvl, mid_byte;
    logic              load_ok, spif, wcol, armed;
    logic [DATA_W-1:0] rx_data;

    // Decode the single-cycle bus access.
    always_comb begin
        reg_sel        = reg_sel_e'(bus_addr);
        bus_op.rd_data = bus_sel && !bus_wr && (reg_sel == REG_DATA);
        bus_op.wr_data = bus_sel &&  bus_wr && (reg_sel == REG_DATA);
        bus_op.rd_stat = bus_sel && !bus_wr && (reg_sel == REG_STAT);
        bus_op.wr_stat = bus_sel &&  bus_wr && (reg_sel == REG_STAT);
    end

    spi_wc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpol     (cfg_cpol),
        .sck_i    (sck_i),
        .ss_n_i   (ss_n_i),
        .mosi_i   (mosi_i),
        .s_lead   (s_lead),
        .s_trail  (s_trail),
        .s_ss_low (s_ss_low),
        .s_mosi   (s_mosi)
    );

    spi_wc_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (m_busy),
        .tick  (m_tick)
    );

    spi_wc_shift #(.W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_master (cfg_master),
        .cpha      (cfg_cpha),
        .load      (load_ok),
        .load_data (bus_wdata),
        .m_tick    (m_tick),
        .s_lead    (s_lead),
        .s_trail   (s_trail),
        .s_ss_low  (s_ss_low),
        .m_sin     (miso_i),
        .s_sin     (s_mosi),
        .window    (coll_window),
        .done      (xfer_done),
        .out_bit   (out_bit),
        .sck_lvl   (sck_lvl),
        .mid_byte  (mid_byte),
        .m_busy    (m_busy),
        .rx_data   (rx_data)
    );

    spi_wc_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (bus_op),
        .window (coll_window),
        .done   (xfer_done),
        .load   (load_ok),
        .spif   (spif),
        .wcol   (wcol),
        .armed  (armed)
    );

    // Register read mux.
    always_comb begin
        bus_rdata = '0;
        if (reg_sel == REG_STAT) begin
            bus_rdata[DONE_BIT] = spif;
            bus_rdata[COLL_BIT] = wcol;
        end else begin
            bus_rdata = rx_data;
        end
    end

    // Pin mapping and interrupt.
    always_comb begin
        irq     = spif;
        sck_o   = cfg_cpol ^ (cfg_master & sck_lvl);
        mosi_o  = cfg_master & out_bit;
        miso_o  = out_bit;
        miso_oe = !cfg_master && s_ss_low && (cfg_cpha ? mid_byte : 1'b1);
    end
endmodule

// File: rtl/spi_wcol_ctrl_chk.sv
// Property checker for spi_wcol_ctrl, attached by bind.
module spi_wcol_ctrl_chk
    import spi_wc_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    cfg_master,
    input logic    mosi_o,
    input logic    irq,
    input logic    spif,
    input logic    wcol,
    input logic    armed,
    input logic    xfer_done,
    input logic    m_tick,
    input logic    coll_window,
    input bus_op_t op
);
    // R4: the collision flag only rises after a data write inside the window.
    assert_wcol_set_by_collision_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wcol) |-> $past(op.wr_data && coll_window));

    // R3: a rejected master write leaves the line untouched when no edge is due.
    assert_coll_keeps_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op.wr_data && coll_window && cfg_master && !m_tick) |=> $stable(mosi_o));

    // R2: the interrupt only rises after a byte completes.
    assert_irq_from_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(xfer_done));

    // R8: status read then data read leaves the collision flag low.
    assert_seq_clears_wcol_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op.rd_data && armed) |=> !wcol);

    // R11: an unarmed data read changes neither flag.
    assert_flags_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op.rd_data && !armed && !xfer_done) |=> ($stable(spif) && $stable(wcol)));
endmodule

bind spi_wcol_ctrl spi_wcol_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_master  (cfg_master),
    .mosi_o      (mosi_o),
    .irq         (irq),
    .spif        (spif),
    .wcol        (wcol),
    .armed       (armed),
    .xfer_done   (xfer_done),
    .m_tick      (m_tick),
    .coll_window (coll_window),
    .op          (bus_op)
);

// File: tb/spi_wcol_ctrl_tb.sv
// Directed bench for spi_wcol_ctrl: one task per scenario.
module spi_wcol_ctrl_tb;
    localparam logic A_DATA = 1'b0;
    localparam logic A_STAT = 1'b1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_master = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq, sck_o, mosi_o;
    logic       sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;
    logic       miso_o, miso_oe;
    int         n_cmp = 0;
    int         n_bad = 0;

    always #2.5 clk = ~clk;

    spi_wcol_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sck_o(sck_o),
        .mosi_o(mosi_o), .miso_i(mosi_o), .sck_i(sck_i), .ss_n_i(ss_n_i),
        .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe(miso_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_irq(output int cycles);
        cycles = 0;
        while (!irq && cycles < 1000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    // Slave byte: drives SCK/MOSI, captures MISO, optional mid-byte write.
    task automatic slave_byte(input logic [7:0] din, input logic coll, output logic [7:0] cap);
        cap = '0;
        for (int i = 7; i >= 0; i--) begin
            if (!cfg_cpha) mosi_i = din[i];
            repeat (8) @(negedge clk);
            if (!cfg_cpha) cap[i] = miso_o;
            sck_i = 1'b1;
            if (cfg_cpha) mosi_i = din[i];
            if (coll && i == 4) begin
                repeat (2) @(negedge clk);
                bus_write(A_DATA, 8'h99);
                repeat (4) @(negedge clk);
            end else begin
                repeat (8) @(negedge clk);
            end
            if (cfg_cpha && i == 7) chk("R7 miso_oe after first edge", miso_oe, 1'b1);
            if (cfg_cpha) cap[i] = miso_o;
            sck_i = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 irq", irq, 1'b0);
        chk("R1 sck idle", sck_o, 1'b0);
        chk("R1 miso_oe", miso_oe, 1'b0);
        bus_read(A_STAT, d); chk("R1 status", d, 8'h00);
        bus_read(A_DATA, d); chk("R1 data", d, 8'h00);
    endtask

    task automatic t_master_basic(input logic cpol, input logic cpha, input logic [7:0] b);
        logic [7:0] d;
        int cyc;
        cfg_master = 1'b1; cfg_cpol = cpol; cfg_cpha = cpha;
        repeat (2) @(negedge clk);
        chk("R2 sck idle level", sck_o, cpol);
        bus_write(A_DATA, b);
        chk("R2 msb first", mosi_o, b[7]);
        chk("R2 sck idle at start", sck_o, cpol);
        wait_irq(cyc);
        chk("R2 transfer length", 8'(cyc), 8'd64);
        bus_read(A_STAT, d); chk("R2 done flag", d, 8'h80);
        bus_read(A_DATA, d); chk("R2 loopback byte", d, b);
        bus_read(A_STAT, d); chk("R8 flags cleared", d, 8'h00);
        chk("R8 irq low", irq, 1'b0);
    endtask

    task automatic t_master_collide();
        logic [7:0] d;
        int cyc;
        cfg_master = 1'b1; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
        bus_write(A_DATA, 8'h3C);
        repeat (10) @(negedge clk);
        bus_write(A_DATA, 8'hFF);
        chk("R4 irq not from wcol", irq, 1'b0);
        bus_read(A_STAT, d); chk("R5 master collision", d, 8'h40);
        wait_irq(cyc);
        bus_read(A_STAT, d); chk("R4 both flags", d, 8'hC0);
        bus_read(A_DATA, d); chk("R3 byte unchanged", d, 8'h3C);
        bus_read(A_STAT, d); chk("R8 both cleared", d, 8'h00);
    endtask

    task automatic t_seq_during();
        logic [7:0] d;
        int cyc;
        bus_write(A_DATA, 8'h11);
        repeat (5) @(negedge clk);
        bus_write(A_DATA, 8'h22);
        bus_read(A_STAT, d); chk("R5 collision flag", d, 8'h40);
        bus_write(A_DATA, 8'h33);
        bus_read(A_STAT, d); chk("R10 write keeps wcol", d, 8'h40);
        bus_read(A_DATA, d);
        bus_read(A_STAT, d); chk("R10 read clears wcol", d, 8'h00);
        wait_irq(cyc);
        bus_read(A_STAT, d); chk("R2 done after sequence", d, 8'h80);
        bus_read(A_DATA, d); chk("R3 byte unchanged", d, 8'h11);
    endtask

    task automatic t_no_clear();
        logic [7:0] d;
        int cyc;
        bus_write(A_DATA, 8'h81);
        wait_irq(cyc);
        bus_read(A_DATA, d); chk("R11 data read value", d, 8'h81);
        chk("R11 unarmed read keeps irq", irq, 1'b1);
        bus_write(A_STAT, 8'h00);
        chk("R11 status write keeps irq", irq, 1'b1);
        bus_read(A_STAT, d); chk("R11 flags kept", d, 8'h80);
        bus_read(A_DATA, d);
        bus_read(A_STAT, d); chk("R8 cleared", d, 8'h00);
    endtask

    task automatic t_read_write_ok();
        logic [7:0] d;
        int cyc;
        bus_write(A_DATA, 8'h0F);
        wait_irq(cyc);
        bus_read(A_STAT, d); chk("R9 done seen", d, 8'h80);
        bus_write(A_DATA, 8'hF0);
        bus_read(A_STAT, d); chk("R9 accepted write clears", d, 8'h00);
        wait_irq(cyc);
        bus_read(A_STAT, d);
        bus_read(A_DATA, d); chk("R9 new byte sent", d, 8'hF0);
    endtask

    task automatic t_slave_cpha0();
        logic [7:0] d, cap;
        cfg_master = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
        repeat (4) @(negedge clk);
        bus_write(A_DATA, 8'h96);
        bus_read(A_STAT, d); chk("R6 write with SS high ok", d, 8'h00);
        chk("R6 miso_oe off with SS high", miso_oe, 1'b0);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 miso_oe on SS low", miso_oe, 1'b1);
        chk("R6 msb shown", miso_o, 1'b1);
        bus_write(A_DATA, 8'h55);
        bus_read(A_STAT, d); chk("R6 write after SS low collides", d, 8'h40);
        slave_byte(8'h3B, 1'b0, cap);
        chk("R12 slave shifted out", cap, 8'h96);
        chk("R12 irq", irq, 1'b1);
        bus_read(A_STAT, d); chk("R4 slave flags", d, 8'hC0);
        bus_write(A_DATA, 8'h77);
        bus_read(A_STAT, d); chk("R9 colliding write keeps wcol", d, 8'h40);
        bus_read(A_DATA, d); chk("R12 slave received", d, 8'h3B);
        bus_read(A_STAT, d); chk("R8 slave cleared", d, 8'h00);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_slave_cpha1();
        logic [7:0] d, cap;
        cfg_master = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b1;
        bus_write(A_DATA, 8'hC3);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 miso_oe off before edge", miso_oe, 1'b0);
        bus_write(A_DATA, 8'h24);
        bus_read(A_STAT, d); chk("R7 write before edge ok", d, 8'h00);
        slave_byte(8'hE1, 1'b1, cap);
        chk("R7 slave shifted out", cap, 8'h24);
        bus_read(A_STAT, d); chk("R7 mid-byte collision", d, 8'hC0);
        bus_read(A_DATA, d); chk("R12 slave received", d, 8'hE1);
        bus_read(A_STAT, d); chk("R8 cleared", d, 8'h00);
        ss_n_i = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_master_basic(1'b0, 1'b0, 8'hA5);
        t_master_basic(1'b1, 1'b1, 8'h5A);
        t_master_collide();
        t_seq_during();
        t_no_clear();
        t_read_write_ok();
        t_slave_cpha0();
        t_slave_cpha1();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule